// File: doc/BRIEF.md
# Power-up Reset Delay and Low-Power Mode Controller

This block keeps the processor core in reset for a fixed interval after any of three events and runs the core's two sleep modes. The interval is measured by a one-shot counter on a slow, separate RC clock. Three events start it:

- the supply coming up;
- a watchdog timeout;
- leaving the deep sleep mode, unless a skip bit is set.

The reset output goes low at once, without waiting for a clock. It comes back high only on the main clock, after a two-stage release.

The core asks for sleep with a request pulse. The request is taken only when the core also flags an instruction boundary, meaning the pipeline has been flushed. In the light sleep mode, only the CPU clock enable is removed. Peripherals and interrupt sources keep running, and an enabled interrupt request wakes the core. In the deep sleep mode, the CPU and peripheral enables are both removed. Only a dedicated recovery input ends it. That recovery then either restarts the reset delay or, with the skip bit set, returns straight to run.

Top module: `sleep_reset_ctl`

## Requirements
- R1: While `supply_ok` is 0, `core_rst_n` is 0. After `supply_ok` rises, `core_rst_n` stays 0 for `RST_CYCLES` RC-clock periods plus the synchroniser delays, then goes to 1.
- R2: A one-cycle `wdt_timeout` pulse pulls `core_rst_n` low within three RC periods. It holds it low for `RST_CYCLES` RC periods, plus at most two main-clock edges for the release.
- R3: In deep sleep, `stop_wake` with `stop_skip_delay`=0 starts a full reset delay. With `stop_skip_delay`=1, the block returns to run on the next main-clock edge and `core_rst_n` stays 1.
- R4: A new trigger that arrives while the delay is counting restarts the count from zero, which lengthens the total reset time.
- R5: While `core_rst_n` is 0, `cpu_clk_en` and `periph_clk_en` are both 0. After release, the block is in run mode with both enables at 1, whatever mode it was in before.
- R6: In run mode, a sleep request is taken only when `sleep_req` and `insn_boundary` are both 1 at a clock edge. `sleep_stop`=1 selects deep sleep and `sleep_stop`=0 selects light sleep. A request without `insn_boundary` has no effect.
- R7: In light sleep, `cpu_clk_en`=0 and `periph_clk_en`=1. A clock edge that sees `irq_wake`=1 returns the block to run. `stop_wake` has no effect in this mode.
- R8: In deep sleep, both enables are 0. `irq_wake` has no effect; only `stop_wake` ends the mode.
- R9: `stop_skip_delay` affects only deep-sleep recovery. A watchdog timeout still runs the full delay when the bit is 1.
- R10: `core_rst_n` falls asynchronously: a fall of `supply_ok` drives it to 0 before the next main-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rc_clk | input | 1 | Slow RC clock for the delay counter |
| supply_ok | input | 1 | Supply good level; 0 forces reset |
| wdt_timeout | input | 1 | Watchdog timeout pulse (main clock) |
| sleep_req | input | 1 | Sleep instruction request from the core |
| sleep_stop | input | 1 | 1 = deep sleep, 0 = light sleep |
| insn_boundary | input | 1 | Pipeline flushed at this edge |
| irq_wake | input | 1 | Enabled interrupt request pending |
| stop_wake | input | 1 | Deep-sleep recovery event |
| stop_skip_delay | input | 1 | Skip reset delay after deep-sleep recovery |
| core_rst_n | output | 1 | Active-low core reset |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |

## Verification
The mode enables come from main-clock registers. A request or wake-up seen at one rising edge therefore changes the enables right after that edge. The bench drives inputs and compares against its behavioural mode model on every falling edge, so each result is checked half a cycle after it is due.

The reset output crosses clock domains, so its timing is checked as counts of main-clock falling edges against windows:
- its fall comes at most three RC periods after a trigger;
- its low time is `RST_CYCLES` RC periods plus the two-edge release;
- the power-up path adds two extra RC periods.

The asynchronous fall of the reset output is checked one nanosecond after `supply_ok` drops, before any clock edge.

// File: rtl/sleep_reset_ctl.sv
module sleep_reset_ctl #(
  parameter int RST_CYCLES = 160,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rc_clk,
  input  logic supply_ok,
  input  logic wdt_timeout,
  input  logic sleep_req,
  input  logic sleep_stop,
  input  logic insn_boundary,
  input  logic irq_wake,
  input  logic stop_wake,
  input  logic stop_skip_delay,
  output logic core_rst_n,
  output logic cpu_clk_en,
  output logic periph_clk_en
);

  typedef enum logic [1:0] {S_RUN, S_HALT, S_STOP, S_RECOV} mode_t;

  mode_t          mode;
  logic           wdt_tog, rec_tog;
  logic [1:0]     por_q;
  logic [2:0]     wdt_s, rec_s;
  logic           busy;
  logic [CW-1:0]  cnt;
  logic [1:0]     rel_q;

  wire por_rc_n = por_q[1];
  wire trig     = (wdt_s[1] ^ wdt_s[2]) | (rec_s[1] ^ rec_s[2]);
  wire last     = (cnt == CW'(RST_CYCLES - 1));
  wire rec_fire = (mode == S_STOP) && stop_wake && !stop_skip_delay;

  // RC clock domain: power-up release, trigger synchronisers, one-shot
  always_ff @(posedge rc_clk or negedge supply_ok)
    if (!supply_ok) por_q <= '0;
    else            por_q <= {por_q[0], 1'b1};

  always_ff @(posedge rc_clk or negedge supply_ok)
    if (!supply_ok) begin
      wdt_s <= '0;
      rec_s <= '0;
    end else begin
      wdt_s <= {wdt_s[1:0], wdt_tog};
      rec_s <= {rec_s[1:0], rec_tog};
    end

  always_ff @(posedge rc_clk or negedge por_rc_n)
    if (!por_rc_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (trig) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end

  // Main clock domain: event toggles, reset release, mode state
  always_ff @(posedge clk or negedge supply_ok)
    if (!supply_ok) begin
      wdt_tog <= 1'b0;
      rec_tog <= 1'b0;
    end else begin
      if (wdt_timeout) wdt_tog <= ~wdt_tog;
      if (rec_fire)    rec_tog <= ~rec_tog;
    end

  always_ff @(posedge clk or posedge busy)
    if (busy) rel_q <= '0;
    else      rel_q <= {rel_q[0], 1'b1};

  assign core_rst_n = rel_q[1];

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) mode <= S_RUN;
    else begin
      case (mode)
        S_RUN:   if (sleep_req && insn_boundary) mode <= sleep_stop ? S_STOP : S_HALT;
        S_HALT:  if (irq_wake) mode <= S_RUN;
        S_STOP:  if (stop_wake) mode <= stop_skip_delay ? S_RUN : S_RECOV;
        default: mode <= S_RECOV;
      endcase
    end

  assign cpu_clk_en    = core_rst_n && (mode == S_RUN);
  assign periph_clk_en = core_rst_n && (mode == S_RUN || mode == S_HALT);

  a_r5_enables_off_in_reset: assert property (@(posedge clk) disable iff (!supply_ok)
    !core_rst_n |-> (!cpu_clk_en && !periph_clk_en));

  a_r6_no_accept_off_boundary: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cpu_clk_en && sleep_req && !insn_boundary) |=> cpu_clk_en);

  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mode == S_HALT && !irq_wake) |=> (periph_clk_en && !cpu_clk_en));

  a_r8_stop_ignores_irq: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mode == S_STOP && !stop_wake) |=> (!periph_clk_en && !cpu_clk_en));

  a_r3_skip_resumes: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mode == S_STOP && stop_wake && stop_skip_delay) |=> cpu_clk_en);

  a_r4_count_holds_reset: assert property (@(posedge rc_clk) disable iff (!por_rc_n)
    (busy && !last) |=> busy);

endmodule

// File: tb/test_sleep_reset_ctl.sv
module test_sleep_reset_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int RC_RATIO   = 4;
  localparam int RST        = 8;

  logic clk = 0, rc_clk = 0;
  logic supply_ok = 0, wdt_timeout = 0, sleep_req = 0, sleep_stop = 0;
  logic insn_boundary = 0, irq_wake = 0, stop_wake = 0, stop_skip_delay = 0;
  logic core_rst_n, cpu_clk_en, periph_clk_en;

  int checks = 0, failures = 0;
  int rs = 0;
  bit cmp_on = 0, done = 0;

  sleep_reset_ctl #(.RST_CYCLES(RST)) i_sleep_reset_ctl (
    .clk(clk), .rc_clk(rc_clk), .supply_ok(supply_ok), .wdt_timeout(wdt_timeout),
    .sleep_req(sleep_req), .sleep_stop(sleep_stop), .insn_boundary(insn_boundary),
    .irq_wake(irq_wake), .stop_wake(stop_wake), .stop_skip_delay(stop_skip_delay),
    .core_rst_n(core_rst_n), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #2;
    forever #(CLK_PERIOD*RC_RATIO/2) rc_clk = ~rc_clk;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural mode model: 0 run, 1 light sleep, 2 deep sleep, 3 recovering
  always @(posedge clk) begin
    if (!core_rst_n) rs = 0;
    else case (rs)
      0: if (sleep_req && insn_boundary) rs = sleep_stop ? 2 : 1;
      1: if (irq_wake) rs = 0;
      2: if (stop_wake) rs = stop_skip_delay ? 0 : 3;
      default: rs = 3;
    endcase
  end

  always @(negedge clk) if (cmp_on) begin
    automatic bit ec = core_rst_n && rs == 0;
    automatic bit ep = core_rst_n && (rs == 0 || rs == 1);
    automatic string tg = !core_rst_n ? "R5" : rs == 0 ? "R6" : rs == 1 ? "R7" : rs == 2 ? "R8" : "R3";
    chk(cpu_clk_en == ec, tg, "cpu_clk_en vs model", cpu_clk_en, ec);
    chk(periph_clk_en == ep, tg, "periph_clk_en vs model", periph_clk_en, ep);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int lat, output int low);
    lat = 0; low = 0;
    while (core_rst_n && lat < 400) begin @(negedge clk); lat++; end
    while (!core_rst_n && low < 4000) begin @(negedge clk); low++; end
  endtask

  task automatic wdt_pulse();
    wdt_timeout = 1; cyc(1); wdt_timeout = 0;
  endtask

  task automatic run_ok(input string tag);
    chk(core_rst_n === 1'b1, tag, "core_rst_n after release", core_rst_n, 1);
    chk(cpu_clk_en === 1'b1 && periph_clk_en === 1'b1, tag, "both enables after release",
        {cpu_clk_en, periph_clk_en}, 3);
  endtask

  initial begin
    int lat, low, hi;
    cyc(3);
    cmp_on = 1;
    cyc(5);
    chk(core_rst_n === 1'b0, "R1", "reset while supply fails", core_rst_n, 0);
    chk(!cpu_clk_en && !periph_clk_en, "R5", "enables off in reset", {cpu_clk_en, periph_clk_en}, 0);

    supply_ok = 1;
    measure(lat, low);
    chk(lat == 0, "R1", "reset still held at supply rise", lat, 0);
    chk(low >= (RST+1)*RC_RATIO && low <= (RST+2)*RC_RATIO+3, "R1", "power-up reset length",
        low, (RST+1)*RC_RATIO);
    cyc(1); run_ok("R5");

    sleep_req = 1; insn_boundary = 0; sleep_stop = 0; cyc(1); sleep_req = 0;
    cyc(2);
    chk(cpu_clk_en === 1'b1, "R6", "request without boundary ignored", cpu_clk_en, 1);

    sleep_req = 1; insn_boundary = 1; sleep_stop = 0; cyc(1); sleep_req = 0; insn_boundary = 0;
    chk(!cpu_clk_en && periph_clk_en, "R7", "light sleep enables", {cpu_clk_en, periph_clk_en}, 1);
    stop_wake = 1; cyc(1); stop_wake = 0; cyc(2);
    chk(!cpu_clk_en && periph_clk_en, "R7", "stop_wake ignored in light sleep",
        {cpu_clk_en, periph_clk_en}, 1);
    irq_wake = 1; cyc(1); irq_wake = 0;
    chk(cpu_clk_en === 1'b1, "R7", "irq wakes light sleep", cpu_clk_en, 1);

    sleep_req = 1; insn_boundary = 1; sleep_stop = 1; cyc(1); sleep_req = 0; insn_boundary = 0;
    chk(!cpu_clk_en && !periph_clk_en, "R8", "deep sleep enables", {cpu_clk_en, periph_clk_en}, 0);
    irq_wake = 1; cyc(3); irq_wake = 0; cyc(1);
    chk(!cpu_clk_en && !periph_clk_en, "R8", "irq ignored in deep sleep", {cpu_clk_en, periph_clk_en}, 0);
    stop_skip_delay = 1; stop_wake = 1; cyc(1); stop_wake = 0;
    chk(cpu_clk_en === 1'b1, "R3", "skip recovery resumes next edge", cpu_clk_en, 1);
    hi = 0;
    for (int k = 0; k < 20 * RC_RATIO; k++) begin cyc(1); if (core_rst_n) hi++; end
    chk(hi == 20 * RC_RATIO, "R3", "no reset after skip recovery", hi, 20 * RC_RATIO);

    stop_skip_delay = 0;
    sleep_req = 1; insn_boundary = 1; sleep_stop = 1; cyc(1); sleep_req = 0; insn_boundary = 0;
    stop_wake = 1; cyc(1); stop_wake = 0;
    measure(lat, low);
    chk(lat <= 3*RC_RATIO+2, "R3", "recovery reset latency", lat, 3*RC_RATIO);
    chk(low >= RST*RC_RATIO && low <= RST*RC_RATIO+3, "R3", "recovery reset length", low, RST*RC_RATIO);
    cyc(1); run_ok("R5");

    sleep_req = 1; insn_boundary = 1; sleep_stop = 0; cyc(1); sleep_req = 0; insn_boundary = 0;
    cyc(2);
    wdt_pulse();
    measure(lat, low);
    chk(lat <= 3*RC_RATIO+2, "R2", "watchdog reset latency", lat, 3*RC_RATIO);
    chk(low >= RST*RC_RATIO && low <= RST*RC_RATIO+3, "R2", "watchdog reset length", low, RST*RC_RATIO);
    cyc(1); run_ok("R5");

    wdt_pulse();
    lat = 0;
    while (core_rst_n && lat < 400) begin cyc(1); lat++; end
    cyc(12);
    wdt_pulse();
    low = 13;
    while (!core_rst_n && low < 4000) begin cyc(1); low++; end
    chk(low >= RST*RC_RATIO + 12, "R4", "restart lengthens reset", low, RST*RC_RATIO + 12);
    chk(low <= RST*RC_RATIO + 12 + 3*RC_RATIO + 6, "R4", "restart reset bounded", low,
        RST*RC_RATIO + 12 + 3*RC_RATIO + 6);
    cyc(1);

    stop_skip_delay = 1;
    wdt_pulse();
    measure(lat, low);
    chk(low >= RST*RC_RATIO && low <= RST*RC_RATIO+3, "R9", "watchdog delay with skip bit set",
        low, RST*RC_RATIO);
    stop_skip_delay = 0;
    cyc(2);

    #1 supply_ok = 0;
    #1 chk(core_rst_n === 1'b0, "R10", "asynchronous reset on supply loss", core_rst_n, 0);
    cyc(3);
    supply_ok = 1;
    measure(lat, low);
    chk(low >= (RST+1)*RC_RATIO && low <= (RST+2)*RC_RATIO+3, "R1", "second power-up length",
        low, (RST+1)*RC_RATIO);
    cyc(1); run_ok("R5");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule